// File: doc/BRIEF.md
# Serial Tuning-Word Loader

This block takes programming words from a three-wire serial bus (bus clock, bus data, bus enable) and turns them into the control settings of a frequency synthesiser. While the enable line is high, each rising edge of the bus clock shifts one data bit into a 26-bit shift register, most significant bit first. When enable falls, the word is split into fields. The port, test, pump-current and reference-divider fields go to their output registers at once.

The 17-bit divider ratio is handled differently. It is parked in a pending register and only reaches its output when the programmable divider reports a cycle boundary. Because of this, a new ratio never cuts a divider cycle short, and fine tuning steps stay smooth. All three bus lines are brought into the system clock domain through two-flop synchronisers, and their edges are found from the synchronised values. The boundary strobe is a one-cycle pulse in the system clock domain.

Top module: `tuner_ctrl_loader`

## Requirements
- R1: While reset is high and on the first edge after it, every output is zero. Port select 00 means both ports are off.
- R2: A rising bus clock edge seen while enable is high shifts bus data into the shift register, most significant bit first. The word maps as follows:
  - bits 25:24 are the port select, with bit 25 as its high bit;
  - bit 23 is the test enable;
  - bits 22:21 are the pump-current code;
  - bits 20:18 are the reference code;
  - bit 17 is the reference mode;
  - bits 16:0 are the divider ratio.
- R3: Bus clock edges seen while enable is low leave the shift register unchanged. This is visible at the outputs when a later enable pulse with no clocks transfers the register.
- R4: A falling enable transfers bits 25:17 to the control outputs.
  - The change appears on the third system clock edge, counting from the first edge that samples enable low.
  - At all other times these outputs hold their value.
- R5: The divider ratio output changes only on a boundary strobe, and only when a transferred word is pending. A strobe with nothing pending leaves the output unchanged.
- R6: A boundary strobe in the same cycle as a transfer does not apply the word just transferred. That word waits for a later strobe.
- R7: If a second transfer arrives before a strobe, it replaces the pending ratio, and the next strobe applies the newer one.
- R8: When more or fewer than 26 bits are shifted, the transfer uses the last 26 bits received. This can include bits left over from earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial bus clock (asynchronous) |
| bus_data | input | 1 | Serial bus data (asynchronous) |
| bus_en | input | 1 | Serial bus enable (asynchronous) |
| div_boundary | input | 1 | One-cycle pulse marking a divider cycle boundary |
| port_sel_o | output | 2 | Port select field, 00 = ports off |
| test_mode_o | output | 1 | Test enable field |
| pump_code_o | output | 2 | Charge-pump current code |
| ref_code_o | output | 3 | Reference divider code |
| ref_mode_o | output | 1 | Reference divider mode |
| div_ratio_o | output | 17 | Programmable divider ratio |

## Verification
The assertions assume two things about the inputs:
- the boundary strobe is a synchronous single-cycle pulse;
- bus data is stable for at least two system clocks on either side of each bus clock rising edge, so that the synchronised data and clock line up.

The stimulus holds each bus phase for several system clock cycles and changes data only while the bus clock is low. It places boundary pulses both apart from transfers and in the exact cycle of one, and it sends words that are longer and shorter than 26 bits.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;

  // Control fields of one word, from its top bit downwards.
  typedef struct packed {
    logic [1:0] port_sel;
    logic       test_en;
    logic [1:0] pump_code;
    logic [2:0] ref_code;
    logic       ref_mode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_s,
  input  logic              bdata_s,
  input  logic              ben_s,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);

  logic              bclk_d, ben_d;
  logic [WORD_W-1:0] sreg_q;
  logic              rise;

  assign rise   = bclk_s & ~bclk_d;
  assign load_o = ben_d & ~ben_s;
  assign word_o = sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      ben_d  <= 1'b0;
      sreg_q <= '0;
    end else begin
      bclk_d <= bclk_s;
      ben_d  <= ben_s;
      if (rise && ben_s) sreg_q <= {sreg_q[WORD_W-2:0], bdata_s};
    end
  end

  // R3
  gated_clock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ben_s |=> $stable(sreg_q));

endmodule

// File: rtl/ctrl_latch.sv
module ctrl_latch
  import synth_ctrl_pkg::*;
#(
  parameter int WORD_W = 26,
  parameter int DIV_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  input  logic              boundary_i,
  output cfg_t              cfg_o,
  output logic [DIV_W-1:0]  div_o
);

  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q, pend_word_q;
  logic             pend_q;
  logic             apply;

  assign apply = boundary_i & pend_q;
  assign cfg_o = cfg_q;
  assign div_o = div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      div_q       <= '0;
      pend_word_q <= '0;
      pend_q      <= 1'b0;
    end else begin
      if (apply) div_q <= pend_word_q;
      if (load_i) begin
        cfg_q       <= cfg_t'(word_i[WORD_W-1 -: CFG_W]);
        pend_word_q <= word_i[DIV_W-1:0];
        pend_q      <= 1'b1;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && div_q == '0));

  // R4
  cfg_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> $past(load_i));

  // R5
  div_only_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_q) |-> $past(boundary_i));

  // R6
  same_cycle_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && boundary_i && !pend_q) |=> $stable(div_q));

  // R7
  pending_set_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> pend_q);

endmodule

// File: rtl/tuner_ctrl_loader.sv
module tuner_ctrl_loader
  import synth_ctrl_pkg::*;
#(
  parameter int WORD_W      = 26,
  parameter int DIV_W       = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_clk,
  input  logic             bus_data,
  input  logic             bus_en,
  input  logic             div_boundary,
  output logic [1:0]       port_sel_o,
  output logic             test_mode_o,
  output logic [1:0]       pump_code_o,
  output logic [2:0]       ref_code_o,
  output logic             ref_mode_o,
  output logic [DIV_W-1:0] div_ratio_o
);

  localparam int BUS_W = 3;

  logic [BUS_W-1:0]  bus_s;
  logic [WORD_W-1:0] word;
  logic              load;
  cfg_t              cfg;

  bus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bus_clk, bus_data, bus_en}),
    .q_o (bus_s)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .bclk_s  (bus_s[2]),
    .bdata_s (bus_s[1]),
    .ben_s   (bus_s[0]),
    .word_o  (word),
    .load_o  (load)
  );

  ctrl_latch #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .word_i     (word),
    .load_i     (load),
    .boundary_i (div_boundary),
    .cfg_o      (cfg),
    .div_o      (div_ratio_o)
  );

  assign port_sel_o  = cfg.port_sel;
  assign test_mode_o = cfg.test_en;
  assign pump_code_o = cfg.pump_code;
  assign ref_code_o  = cfg.ref_code;
  assign ref_mode_o  = cfg.ref_mode;

endmodule

// File: tb/tuner_ctrl_loader_bench.sv
module tuner_ctrl_loader_bench;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b0, div_boundary = 1'b0;
  logic [1:0]  port_sel_o, pump_code_o;
  logic        test_mode_o, ref_mode_o;
  logic [2:0]  ref_code_o;
  logic [16:0] div_ratio_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tuner_ctrl_loader u_tuner_ctrl_loader (
    .clk(clk), .rst(rst), .bus_clk(bus_clk), .bus_data(bus_data), .bus_en(bus_en),
    .div_boundary(div_boundary), .port_sel_o(port_sel_o), .test_mode_o(test_mode_o),
    .pump_code_o(pump_code_o), .ref_code_o(ref_code_o), .ref_mode_o(ref_mode_o),
    .div_ratio_o(div_ratio_o)
  );

  // Behavioural reference model
  logic [2:0]  hist[$];
  logic [25:0] m_word;
  logic [8:0]  m_cfg;
  logic [16:0] m_div, m_pend;
  bit          m_pend_v;

  always @(posedge clk) begin
    if (rst) begin
      hist = {3'b000, 3'b000, 3'b000};
      m_word = '0; m_cfg = '0; m_div = '0; m_pend = '0; m_pend_v = 0;
    end else begin
      logic [2:0] cur, old;
      hist.push_back({bus_clk, bus_data, bus_en});
      cur = hist[hist.size()-3];
      old = hist[hist.size()-4];
      void'(hist.pop_front());
      if (div_boundary && m_pend_v) m_div = m_pend;
      if (old[0] && !cur[0]) begin
        m_cfg = m_word[25:17]; m_pend = m_word[16:0]; m_pend_v = 1;
      end else if (div_boundary && m_pend_v) m_pend_v = 0;
      if (cur[2] && !old[2] && cur[0]) m_word = {m_word[24:0], cur[1]};
    end
  end

  function automatic logic [8:0] dut_cfg();
    return {port_sel_o, test_mode_o, pump_code_o, ref_code_o, ref_mode_o};
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (dut_cfg() !== m_cfg) begin
        errors++;
        $display("FAIL R4 cfg actual=%h expected=%h", dut_cfg(), m_cfg);
      end
      checks++;
      if (div_ratio_o !== m_div) begin
        errors++;
        $display("FAIL R5 div actual=%h expected=%h", div_ratio_o, m_div);
      end
    end
  end

  task automatic check_out(string tag, logic [8:0] ecfg, logic [16:0] ediv);
    checks++;
    if (dut_cfg() !== ecfg || div_ratio_o !== ediv) begin
      errors++;
      $display("FAIL %s actual=%h/%h expected=%h/%h", tag, dut_cfg(), div_ratio_o, ecfg, ediv);
    end
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Shift nbits of val, MSB first; optionally pulse boundary in the transfer cycle.
  task automatic send(logic [39:0] val, int nbits, bit coincide);
    @(negedge clk); bus_en = 1'b1; waitn(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      bus_data = val[i]; waitn(2);
      bus_clk = 1'b1; waitn(3);
      bus_clk = 1'b0; waitn(2);
    end
    bus_en = 1'b0;
    if (coincide) begin
      waitn(2); div_boundary = 1'b1; waitn(1); div_boundary = 1'b0; waitn(3);
    end else waitn(5);
  endtask

  task automatic strobe();
    @(negedge clk); div_boundary = 1'b1;
    @(negedge clk); div_boundary = 1'b0;
    waitn(2);
  endtask

  localparam logic [25:0] WA = 26'h3A51234;
  localparam logic [25:0] WB = 26'h15CF0F1;
  localparam logic [25:0] WC = 26'h0F38888;
  localparam logic [25:0] WD = 26'h2E04321;
  localparam logic [9:0]  V10 = 10'h3C5;

  initial begin
    logic [25:0] mix;
    waitn(4);
    check_out("R1 during reset", '0, '0);
    rst = 1'b0; waitn(2);
    check_out("R1 after reset", '0, '0);

    // R2 / R4 / R5: fields at once, ratio waits for a boundary
    send({14'd0, WA}, 26, 0);
    check_out("R2 fields of WA", WA[25:17], '0);
    waitn(6);
    check_out("R5 ratio held without strobe", WA[25:17], '0);
    strobe();
    check_out("R5 ratio after strobe", WA[25:17], WA[16:0]);
    strobe();
    check_out("R5 strobe with none pending", WA[25:17], WA[16:0]);

    // R3: clock edges with enable low are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bus_data = 1'b1; waitn(2);
      bus_clk = 1'b1; waitn(3); bus_clk = 1'b0; waitn(2);
    end
    send('0, 0, 0);
    check_out("R3 empty transfer keeps word", WA[25:17], WA[16:0]);
    strobe();
    check_out("R3 ratio from untouched register", WA[25:17], WA[16:0]);

    // R6: strobe in the transfer cycle does not apply the new word
    send({14'd0, WB}, 26, 1);
    check_out("R6 same-cycle strobe defers", WB[25:17], WA[16:0]);
    strobe();
    check_out("R6 later strobe applies", WB[25:17], WB[16:0]);

    // R7: newer pending word wins
    send({14'd0, WC}, 26, 0);
    send({14'd0, WD}, 26, 0);
    check_out("R7 second word fields", WD[25:17], WB[16:0]);
    strobe();
    check_out("R7 newest ratio applied", WD[25:17], WD[16:0]);

    // R8: long and short words
    send({10'd0, 4'hF, WB}, 30, 0);
    strobe();
    check_out("R8 long word keeps last 26", WB[25:17], WB[16:0]);
    send({30'd0, V10}, 10, 0);
    mix = {WB[15:0], V10};
    strobe();
    check_out("R8 short word mixes old bits", mix[25:17], mix[16:0]);

    waitn(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule